// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. Each phase input is first brought into the clock domain by a two-stage synchronizer. It can then be inverted, and it passes through a programmable glitch filter. The filter samples at a rate set by a clock divider. The cleaned levels go to an edge detector and a direction decoder. A three-bit mode input chooses which phase edges move the counter: phase A only, phase B only, or every edge of both phases.

The counter runs between zero and a programmable period. Moving up past the period returns it to zero. Moving down below zero loads the period. Either wrap sets a sticky event flag, which is cleared by a write-one strobe. A status output shows the direction of the most recent counted step. Configuration arrives as plain inputs from a register block that sits outside this design.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `count_o` is 0, `dir_down_o` is 0 and `wrap_flag_o` is 0.
- R2: With `mode_sel_i` = 3'b001, only edges of filtered phase A move the counter. A rising A edge counts up when B is low and down when B is high, and a falling A edge does the opposite.
- R3: With `mode_sel_i` = 3'b010, only edges of filtered phase B move the counter. A rising B edge counts up when A is high and down when A is low, and a falling B edge does the opposite.
- R4: With `mode_sel_i` = 3'b011, every edge of either phase moves the counter by one, using the rules of R2 and R3. An edge on both phases in the same cycle is invalid and leaves the count unchanged.
- R5: Any other `mode_sel_i` value holds both `count_o` and `dir_down_o`, whatever the phase inputs do.
- R6: `dir_down_o` takes the direction of the most recent counted step: 0 for up, 1 for down.
- R7: An up step taken when the count is at or above `period_i` loads 0 and sets `wrap_flag_o`.
- R8: A down step taken at count 0 loads `period_i` and sets `wrap_flag_o`.
- R9: `wrap_flag_o` stays set until a cycle with `wrap_clr_i` high. If a wrap and the clear fall in the same cycle, the flag ends up set.
- R10: When `inv_a_i` or `inv_b_i` is 1, that phase is inverted before filtering. Inverting one phase reverses the counting direction of a given rotation.
- R11: With filter setting N (0 to 15), a filtered level changes only after N+1 consecutive samples at the new level. Shorter pulses are ignored.
- R12: The filter takes one sample every `prescale_i`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a_i | input | 1 | Encoder phase A pin level |
| phase_b_i | input | 1 | Encoder phase B pin level |
| mode_sel_i | input | 3 | Counting mode: 001 A edges, 010 B edges, 011 both, other values hold |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| filt_a_i | input | 4 | Phase A filter length N |
| filt_b_i | input | 4 | Phase B filter length N |
| period_i | input | 16 | Wrap value of the counter |
| prescale_i | input | 16 | Filter sample divider, one sample every value+1 cycles |
| wrap_clr_i | input | 1 | Write-one clear strobe for the wrap flag |
| count_o | output | 16 | Position count |
| dir_down_o | output | 1 | Direction of the last counted step, 1 meaning down |
| wrap_flag_o | output | 1 | Sticky wrap event flag |

## Verification
Two functions can meet in the same cycle: setting the wrap flag on a counter wrap and clearing it through the strobe. The bench holds `wrap_clr_i` high without a break while it drives a phase edge that takes the count past the period. A monitor counts the cycles in which the flag is high. The result is correct only if the flag shows for exactly one cycle, because the set wins in the wrap cycle and the held clear removes it one cycle later.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam logic [2:0] MODE_PH_A  = 3'b001;
  localparam logic [2:0] MODE_PH_B  = 3'b010;
  localparam logic [2:0] MODE_PH_AB = 3'b011;

  typedef struct packed {
    logic en;
    logic down;
  } qenc_step_t;
endpackage

// File: rtl/qenc_prescaler.sv
module qenc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= div_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qenc_input_cond.sv
module qenc_input_cond #(
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic             inv_i,
  input  logic [FLT_W-1:0] len_i,
  input  logic             tick_i,
  output logic             level_o
);
  logic             sync1_q, sync2_q;
  logic             lvl_q, lvl_d;
  logic [FLT_W-1:0] run_q, run_d;

  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (tick_i) begin
      if (sync2_q == lvl_q) begin
        run_d = '0;
      end else if (run_q >= len_i) begin
        lvl_d = sync2_q;
        run_d = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw_i ^ inv_i;
      sync2_q <= sync1_q;
      lvl_q   <= lvl_d;
      run_q   <= run_d;
    end
  end

  assign level_o = lvl_q;

  // R12: the filtered level only moves on a sample tick
  a_r12_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(level_o));
  // R11: a new filtered level always equals the synchronized input
  a_r11_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> (level_o == $past(sync2_q)));
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_i,
  input  logic       b_i,
  input  logic [2:0] mode_i,
  output qenc_step_t step_o
);
  logic a_q, b_q;
  logic edge_a, edge_b, up_a, up_b;

  always_comb begin
    edge_a = a_i ^ a_q;
    edge_b = b_i ^ b_q;
    up_a   = a_i ^ b_i;
    up_b   = ~(a_i ^ b_i);
    step_o = '0;
    case (mode_i)
      MODE_PH_A: begin
        step_o.en   = edge_a;
        step_o.down = ~up_a;
      end
      MODE_PH_B: begin
        step_o.en   = edge_b;
        step_o.down = ~up_b;
      end
      MODE_PH_AB: begin
        step_o.en   = edge_a ^ edge_b;
        step_o.down = edge_a ? ~up_a : ~up_b;
      end
      default: step_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end
endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qenc_step_t       step_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             flag_q, flag_d;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (step_i.en) begin
      if (!step_i.down) begin
        if (cnt_q >= period_i) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = period_i;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    dir_d  = step_i.en ? step_i.down : dir_q;
    flag_d = wrap | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      flag_q <= flag_d;
    end
  end

  assign count_o    = cnt_q;
  assign dir_down_o = dir_q;
  assign flag_o     = flag_q;

  // R7: an up step at or past the period lands on zero
  a_r7_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i.en && !step_i.down && count_o >= period_i) |=> (count_o == '0 && flag_o));
  // R8: a down step at zero lands on the period
  a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i.en && step_i.down && count_o == '0) |=> (count_o == $past(period_i) && flag_o));
  // R9: the flag persists without a clear
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  // R6: without a step the count and direction hold
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i.en |=> ($stable(count_o) && $stable(dir_down_o)));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic [2:0]       mode_sel_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic [FLT_W-1:0] filt_a_i,
  input  logic [FLT_W-1:0] filt_b_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DIV_W-1:0] prescale_i,
  input  logic             wrap_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             wrap_flag_o
);
  localparam int NCH = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             tick;
  logic [NCH-1:0]   raw_v, inv_v, lvl_v;
  logic [FLT_W-1:0] len_v [NCH];
  qenc_step_t       step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign raw_v    = {phase_b_i, phase_a_i};
  assign inv_v    = {inv_b_i, inv_a_i};
  assign len_v[0] = filt_a_i;
  assign len_v[1] = filt_b_i;

  qenc_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i_n), .div_i(prescale_i), .tick_o(tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    qenc_input_cond #(.FLT_W(FLT_W)) u_cond (
      .clk(clk), .rst_n(rst_i_n), .raw_i(raw_v[ch]), .inv_i(inv_v[ch]),
      .len_i(len_v[ch]), .tick_i(tick), .level_o(lvl_v[ch])
    );
  end

  qenc_decoder u_dec (
    .clk(clk), .rst_n(rst_i_n), .a_i(lvl_v[0]), .b_i(lvl_v[1]),
    .mode_i(mode_sel_i), .step_o(step)
  );

  qenc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_i_n), .step_i(step), .period_i(period_i),
    .clr_i(wrap_clr_i), .count_o(count_o), .dir_down_o(dir_down_o),
    .flag_o(wrap_flag_o)
  );

  // R5: unsupported mode values freeze the count and direction
  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_sel_i != MODE_PH_A && mode_sel_i != MODE_PH_B && mode_sel_i != MODE_PH_AB)
    |=> ($stable(count_o) && $stable(dir_down_o)));
  // R4: both filtered phases flipping together is not counted
  a_r4_double_edge: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_sel_i == MODE_PH_AB && (lvl_v ^ $past(lvl_v)) == 2'b11) |=> $stable(count_o));
endmodule

// File: tb/qenc_counter_test.sv
`timescale 1ns/1ps
module qenc_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pa, pb;
  logic [2:0]  mode;
  logic        inv_a, inv_b;
  logic [3:0]  fa, fb;
  logic [15:0] period, presc;
  logic        clr;
  logic [15:0] count;
  logic        dir_down, flag;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;
  bit mon_en = 0;
  int flag_hi = 0;

  always #4 clk = ~clk;

  qenc_counter uut (
    .clk(clk), .rst_n(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .mode_sel_i(mode), .inv_a_i(inv_a), .inv_b_i(inv_b),
    .filt_a_i(fa), .filt_b_i(fb), .period_i(period), .prescale_i(presc),
    .wrap_clr_i(clr), .count_o(count), .dir_down_o(dir_down),
    .wrap_flag_o(flag)
  );

  always @(negedge clk) if (mon_en && flag) flag_hi++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0; pa = 1'b0; pb = 1'b0; pos = 0; mode = m;
    clr = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  // forward order of (A,B): 00 -> 10 -> 11 -> 01
  task automatic drive_pos();
    case (pos)
      0: begin pa = 1'b0; pb = 1'b0; end
      1: begin pa = 1'b1; pb = 1'b0; end
      2: begin pa = 1'b1; pb = 1'b1; end
      default: begin pa = 1'b0; pb = 1'b1; end
    endcase
    wait_cyc(80);
  endtask

  task automatic fwd(input int n);
    for (int i = 0; i < n; i++) begin pos = (pos + 1) % 4; drive_pos(); end
  endtask

  task automatic rev(input int n);
    for (int i = 0; i < n; i++) begin pos = (pos + 3) % 4; drive_pos(); end
  endtask

  task automatic t_reset();
    inv_a = 0; inv_b = 0; fa = 0; fb = 0; period = 16'd1000; presc = 0;
    do_reset(3'b000);
    check("R1 count", count, 0);
    check("R1 dir", dir_down, 0);
    check("R1 flag", flag, 0);
  endtask

  task automatic t_mode_a();
    do_reset(3'b001);
    fwd(4);
    check("R2 forward count", count, 2);
    check("R6 forward dir", dir_down, 0);
    rev(4);
    check("R2 reverse count", count, 0);
    check("R6 reverse dir", dir_down, 1);
  endtask

  task automatic t_mode_b();
    do_reset(3'b010);
    fwd(8);
    check("R3 forward count", count, 4);
    rev(2);
    check("R3 reverse count", count, 3);
    check("R3 reverse dir", dir_down, 1);
  endtask

  task automatic t_mode_c();
    do_reset(3'b011);
    fwd(6);
    check("R4 forward count", count, 6);
    rev(2);
    check("R4 reverse count", count, 4);
    pa = 1'b1; pb = 1'b1; pos = 2; wait_cyc(60);
    check("R4 double edge up", count, 4);
    pa = 1'b0; pb = 1'b0; pos = 0; wait_cyc(60);
    check("R4 double edge down", count, 4);
  endtask

  task automatic t_mode_off();
    do_reset(3'b011);
    fwd(3);
    mode = 3'b000;
    rev(4);
    check("R5 mode 000 count", count, 3);
    check("R5 mode 000 dir", dir_down, 0);
    mode = 3'b111;
    rev(2);
    check("R5 mode 111 count", count, 3);
    check("R5 mode 111 dir", dir_down, 0);
  endtask

  task automatic t_wrap_up();
    period = 16'd3;
    do_reset(3'b011);
    fwd(3);
    check("R7 at period", count, 3);
    check("R7 no flag yet", flag, 0);
    fwd(1);
    check("R7 wrap count", count, 0);
    check("R7 wrap flag", flag, 1);
    fwd(1);
    check("R9 flag sticky", flag, 1);
    clr = 1'b1; wait_cyc(1); clr = 1'b0; wait_cyc(2);
    check("R9 flag cleared", flag, 0);
    fwd(1);
    check("R9 no flag without wrap", flag, 0);
  endtask

  task automatic t_wrap_down();
    period = 16'd3;
    do_reset(3'b011);
    rev(1);
    check("R8 wrap count", count, 3);
    check("R8 wrap flag", flag, 1);
  endtask

  task automatic t_same_cycle();
    period = 16'd2;
    do_reset(3'b011);
    clr = 1'b1;
    fwd(2);
    flag_hi = 0; mon_en = 1;
    fwd(1);
    mon_en = 0;
    check("R9 set wins over clear", flag_hi, 1);
    check("R9 final flag", flag, 0);
    check("R7 count after wrap", count, 0);
    clr = 1'b0;
  endtask

  task automatic t_polarity();
    period = 16'd1000;
    inv_a = 1'b1;
    do_reset(3'b000);
    wait_cyc(20);
    mode = 3'b011;
    fwd(4);
    check("R10 inverted count", count, 997);
    check("R10 inverted dir", dir_down, 1);
    mode = 3'b000; inv_a = 1'b0; wait_cyc(20);
  endtask

  task automatic t_filter();
    fa = 4'd3; fb = 4'd3; presc = 0;
    do_reset(3'b001);
    pa = 1'b1; wait_cyc(2); pa = 1'b0; wait_cyc(40);
    check("R11 short pulse count", count, 0);
    check("R11 short pulse dir", dir_down, 0);
    pos = 1; drive_pos();
    check("R11 long level count", count, 1);
  endtask

  task automatic t_prescale();
    fa = 4'd1; fb = 4'd1; presc = 0;
    do_reset(3'b001);
    pa = 1'b1; wait_cyc(4); pa = 1'b0; wait_cyc(40);
    check("R12 no divide pulse dir", dir_down, 1);
    presc = 16'd3;
    do_reset(3'b001);
    pa = 1'b1; wait_cyc(4); pa = 1'b0; wait_cyc(60);
    check("R12 divided pulse dir", dir_down, 0);
    check("R12 divided pulse count", count, 0);
    pos = 1; drive_pos();
    check("R12 divided long count", count, 1);
    fa = 0; fb = 0; presc = 0;
  endtask

  initial begin
    rst_n = 1'b0; pa = 0; pb = 0; mode = 0; clr = 0;
    inv_a = 0; inv_b = 0; fa = 0; fb = 0; period = 16'd1000; presc = 0;
    t_reset();
    t_mode_a();
    t_mode_b();
    t_mode_c();
    t_mode_off();
    t_wrap_up();
    t_wrap_down();
    t_same_cycle();
    t_polarity();
    t_filter();
    t_prescale();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule